// File: doc/BRIEF.md
# Serial Tag-Search Cache

A small fully associative read cache that looks up a request by walking its stored tags one entry per clock through a single shared comparator, steered by an index counter. The search ends at the first valid entry whose tag matches, and the requested word from that entry's line goes back to the CPU. When every entry has been compared without a match, the controller asks external memory for the whole 64-byte line, installs it with its tag, and returns the requested word in the same step.

Any line may sit in any entry. Free entries are filled lowest index first. Once all entries hold data, a round-robin pointer picks the entry to overwrite. Because the comparison is serial, hit latency grows with the position of the entry, and a miss costs one cycle per entry before the fetch begins. The CPU side takes one read at a time and signals completion with a one-cycle ready pulse. The memory side is a request/grant handshake that delivers a full line at once.

Top module: `serial_tag_cache`

## Requirements
- R1: After reset every entry is invalid, cpuReady and memReq are low, and the first read of any line is a miss.
- R2: A read accepted in idle that matches entry k raises cpuReady together with cpuHit=1 exactly k+1 clock edges after the accepting edge.
- R3: Returned data is the 32-bit word of the line chosen by address bits [5:2], where word w occupies line bits [32w+31:32w]. Address bits [1:0] have no effect on the result.
- R4: The tag is address bits [31:6]. Two addresses in the same 64-byte line hit the same entry.
- R5: A miss raises memReq on the edge NUM_ENTRIES cycles after acceptance. memAddr carries the line address with bits [5:0] zero, and both are held stable until memGnt is sampled high.
- R6: On the edge where memReq and memGnt are both high, the line on memData is stored. cpuReady rises on that edge with cpuHit=0 and the requested word taken from memData.
- R7: A fetched line goes to the lowest-indexed invalid entry. When no entry is invalid, it goes to the entry named by a round-robin pointer that starts at 0 after reset and advances by one on each such replacement.
- R8: cpuReady is high for exactly one cycle per read.
- R9: cpuRd and cpuAddr are ignored while a read is being searched or fetched. The result belongs to the accepted address, and memAddr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpuRd | input | 1 | Read strobe, sampled only in idle |
| cpuAddr | input | ADDR_W | Byte address of the read |
| cpuRdata | output | WORD_W | Returned word, valid with cpuReady |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuHit | output | 1 | High with cpuReady when the read hit |
| memReq | output | 1 | Line fetch request |
| memAddr | output | ADDR_W | Line-aligned fetch address |
| memGnt | input | 1 | Memory grant, line valid on memData |
| memData | input | LINE_BYTES*8 | Fetched line |

## Verification
Every cycle, the assertions check the shape of the handshakes: the single-cycle ready pulse, a request held steady with a fixed address until it is granted, a completion that follows each grant as a miss, a hit flag that never appears without ready, and no request left raised next to ready. Only the bench scenarios can show what depends on cache contents. This covers the exact position-dependent hit latency, the data word chosen by the offset bits, placement into the first free entry followed by round-robin eviction, and reads that arrive while the controller is busy and must be ignored. The bench measures these against its own model of tags, valid bits and the replacement pointer.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_FETCH  = 2'd2
  } stcState_e;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic accept;   // latch request, clear index
    logic step;     // advance index counter
    logic hitDone;  // return word from entry at index
    logic fill;     // install fetched line, return word
  } stcStrobe_t;

endpackage

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuRd,
  input  logic       tagMatch,
  input  logic       lastIdx,
  input  logic       memGnt,
  output stcStrobe_t strobe,
  output logic       memReq
);

  stcState_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (cpuRd) begin
          strobe.accept = 1'b1;
          nextState     = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        if (tagMatch) begin
          strobe.hitDone = 1'b1;
          nextState      = ST_IDLE;
        end else if (lastIdx) begin
          nextState = ST_FETCH;
        end else begin
          strobe.step = 1'b1;
        end
      end
      ST_FETCH: begin
        if (memGnt) begin
          strobe.fill = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign memReq = (state == ST_FETCH);

endmodule

// File: rtl/stc_datapath.sv
module stc_datapath
  import stc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int NUM_ENTRIES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  stcStrobe_t              strobe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [LINE_BYTES*8-1:0] memData,
  output logic [WORD_W-1:0]       cpuRdata,
  output logic                    cpuReady,
  output logic                    cpuHit,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    tagMatch,
  output logic                    lastIdx
);

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BSEL_W;
  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [TAG_W-1:0]       reqTag;
  logic [WSEL_W-1:0]      reqWsel;
  logic [IDX_W-1:0]       idx;
  logic [IDX_W-1:0]       rrPtr;
  logic [IDX_W-1:0]       freeIdx;
  logic [IDX_W-1:0]       victim;
  logic                   anyFree;
  logic [NUM_ENTRIES-1:0] validArr;
  logic [TAG_W-1:0]       tagArr  [NUM_ENTRIES];
  logic [LINE_W-1:0]      lineArr [NUM_ENTRIES];

  // Request latch and search index
  always_ff @(posedge clk) begin
    if (strobe.accept) begin
      reqTag  <= cpuAddr[ADDR_W-1:OFF_W];
      reqWsel <= cpuAddr[OFF_W-1:BSEL_W];
      idx     <= '0;
    end else if (strobe.step) begin
      idx <= idx + 1'b1;
    end
  end

  // The one shared comparator
  assign tagMatch = validArr[idx] && (tagArr[idx] == reqTag);
  assign lastIdx  = (idx == IDX_W'(NUM_ENTRIES - 1));
  assign memAddr  = {reqTag, {OFF_W{1'b0}}};

  // Lowest-indexed free entry
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validArr[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign victim = anyFree ? freeIdx : rrPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rrPtr <= '0;
    end else if (strobe.fill && !anyFree) begin
      rrPtr <= (rrPtr == IDX_W'(NUM_ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  // Entry storage, one slice per entry
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        validArr[e] <= 1'b0;
      end else if (strobe.fill && victim == IDX_W'(e)) begin
        validArr[e] <= 1'b1;
        tagArr[e]   <= reqTag;
        lineArr[e]  <= memData;
      end
    end
  end

  // Response register
  logic [LINE_W-1:0] srcLine;
  assign srcLine = strobe.fill ? memData : lineArr[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      cpuReady <= 1'b0;
      cpuHit   <= 1'b0;
      cpuRdata <= '0;
    end else begin
      cpuReady <= strobe.hitDone | strobe.fill;
      cpuHit   <= strobe.hitDone;
      if (strobe.hitDone | strobe.fill)
        cpuRdata <= srcLine[reqWsel*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/serial_tag_cache.sv
module serial_tag_cache
  import stc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int NUM_ENTRIES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpuRd,
  input  logic [ADDR_W-1:0]       cpuAddr,
  output logic [WORD_W-1:0]       cpuRdata,
  output logic                    cpuReady,
  output logic                    cpuHit,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic                    memGnt,
  input  logic [LINE_BYTES*8-1:0] memData
);

  stcStrobe_t strobe;
  logic       tagMatch;
  logic       lastIdx;

  stc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cpuRd    (cpuRd),
    .tagMatch (tagMatch),
    .lastIdx  (lastIdx),
    .memGnt   (memGnt),
    .strobe   (strobe),
    .memReq   (memReq)
  );

  stc_datapath #(
    .ADDR_W      (ADDR_W),
    .WORD_W      (WORD_W),
    .LINE_BYTES  (LINE_BYTES),
    .NUM_ENTRIES (NUM_ENTRIES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .cpuAddr  (cpuAddr),
    .memData  (memData),
    .cpuRdata (cpuRdata),
    .cpuReady (cpuReady),
    .cpuHit   (cpuHit),
    .memAddr  (memAddr),
    .tagMatch (tagMatch),
    .lastIdx  (lastIdx)
  );

endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cpuRd,
  input logic [ADDR_W-1:0]       cpuAddr,
  input logic [WORD_W-1:0]       cpuRdata,
  input logic                    cpuReady,
  input logic                    cpuHit,
  input logic                    memReq,
  input logic [ADDR_W-1:0]       memAddr,
  input logic                    memGnt,
  input logic [LINE_BYTES*8-1:0] memData
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpuReady && !memReq));

  p_hit_with_ready_r2: assert property (@(posedge clk) disable iff (rst)
    cpuHit |-> cpuReady);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr)));

  p_req_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    memReq |-> (memAddr[OFF_W-1:0] == '0));

  p_fill_done_r6: assert property (@(posedge clk) disable iff (rst)
    (memReq && memGnt) |=> (cpuReady && !cpuHit && !memReq));

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cpuReady |=> !cpuReady);

  p_no_req_at_ready_r9: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> !memReq);

endmodule

bind serial_tag_cache stc_checker #(
  .ADDR_W     (ADDR_W),
  .WORD_W     (WORD_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (.*);

// File: tb/serial_tag_cache_tb.sv
module serial_tag_cache_tb;

  localparam int N      = 16;
  localparam int LINE_W = 512;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpuRd = 1'b0;
  logic [31:0]       cpuAddr = '0;
  logic [31:0]       cpuRdata;
  logic              cpuReady;
  logic              cpuHit;
  logic              memReq;
  logic [31:0]       memAddr;
  logic              memGnt = 1'b0;
  logic [LINE_W-1:0] memData = '0;

  int tests = 0;
  int fails = 0;

  logic [25:0] mTag [N];
  bit          mValid [N];
  int          mRr = 0;

  always #2.5 clk = ~clk;

  serial_tag_cache u_dut (
    .clk(clk), .rst(rst), .cpuRd(cpuRd), .cpuAddr(cpuAddr),
    .cpuRdata(cpuRdata), .cpuReady(cpuReady), .cpuHit(cpuHit),
    .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt), .memData(memData)
  );

  function automatic logic [31:0] memWord(logic [25:0] tag, int w);
    return (32'(tag) * 32'h9E3779B1) ^ (32'(w) << 24) ^ 32'(w * 3 + 1);
  endfunction

  function automatic logic [LINE_W-1:0] memLine(logic [25:0] tag);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = memWord(tag, w);
    return l;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Returns expected hit index, or -1 for a miss
  function automatic int modelLookup(logic [25:0] tag);
    for (int i = 0; i < N; i++) if (mValid[i] && mTag[i] == tag) return i;
    return -1;
  endfunction

  function automatic int modelVictim();
    for (int i = 0; i < N; i++) if (!mValid[i]) return i;
    return mRr;
  endfunction

  task automatic doReq(logic [31:0] a, bit poke, output int hitIdx);
    logic [25:0] tag = a[31:6];
    int  w = int'(a[5:2]);
    int  n = 0, dly = 0, dly0 = 0, vic;
    bit  got = 0, reqSeen = 0, gntOn = 0;
    hitIdx = modelLookup(tag);
    cpuRd = 1'b1; cpuAddr = a;
    @(posedge clk);
    @(negedge clk);
    if (poke && hitIdx < 0) begin cpuRd = 1'b1; cpuAddr = ~a; end
    else cpuRd = 1'b0;
    while (!got && n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (cpuReady) got = 1;
      else if (memReq && !gntOn) begin
        if (!reqSeen) begin
          reqSeen = 1;
          check(n == N && hitIdx < 0, "R5", "request cycle", n, N);
          check(memAddr == {tag, 6'd0}, "R5", "fetch address", memAddr, {tag, 6'd0});
          dly = $urandom % 4; dly0 = dly;
        end else begin
          check(memAddr == {tag, 6'd0}, poke ? "R9" : "R5", "held address", memAddr, {tag, 6'd0});
        end
        if (dly == 0) begin
          cpuRd = 1'b0; memData = memLine(tag); memGnt = 1'b1; gntOn = 1;
        end else dly--;
      end
    end
    memGnt = 1'b0;
    cpuRd = 1'b0;
    check(got, "R8", "ready seen", got, 1);
    if (hitIdx >= 0) begin
      check(cpuHit == 1'b1, "R2", "hit flag", cpuHit, 1);
      check(n == hitIdx + 1, "R2", "hit latency", n, hitIdx + 1);
    end else begin
      check(cpuHit == 1'b0, "R6", "miss flag", cpuHit, 0);
      check(n == N + dly0 + 1, "R6", "miss latency", n, N + dly0 + 1);
      vic = modelVictim();
      if (mValid[vic]) mRr = (mRr + 1) % N;
      mValid[vic] = 1; mTag[vic] = tag;
    end
    check(cpuRdata == memWord(tag, w), poke ? "R9" : "R3", "data", cpuRdata, memWord(tag, w));
    @(posedge clk);
    @(negedge clk);
    check(!cpuReady, "R8", "ready pulse width", cpuReady, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int h;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) mValid[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check(!cpuReady && !memReq, "R1", "reset outputs", {cpuReady, memReq}, 0);

    // R1: first access misses; R4: same line other offsets hit entry 0
    doReq(32'h0000_1000, 0, h);  check(h == -1, "R1", "first access miss", h, -1);
    doReq(32'h0000_103D, 0, h);  check(h == 0, "R4", "same line hit", h, 0);
    doReq(32'h0000_1006, 0, h);  check(h == 0, "R3", "byte bits ignored", h, 0);

    // R7: fill remaining entries in order, then round-robin eviction
    for (int i = 1; i < N; i++) doReq(32'h0100_0000 + 32'(i) * 64, 0, h);
    doReq(32'h0100_0000 + 32'(N - 1) * 64 + 8, 0, h);
    check(h == N - 1, "R7", "last entry position", h, N - 1);
    doReq(32'h0200_0000, 0, h);  check(h == -1, "R7", "new line miss", h, -1);
    doReq(32'h0200_0004, 0, h);  check(h == 0, "R7", "evicted slot 0", h, 0);
    doReq(32'h0000_1000, 0, h);  check(h == -1, "R7", "victim gone", h, -1);
    doReq(32'h0000_1000, 0, h);  check(h == 1, "R7", "pointer advanced", h, 1);

    // R9: busy-time strobes ignored
    doReq(32'h0300_0010, 1, h);
    doReq(32'h0300_0014, 0, h);  check(h >= 0, "R9", "poked line resident", h, 0);

    // Random mix over a small line pool
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a;
      a = 32'h0400_0000 + (32'($urandom % 22) << 6) + (32'($urandom % 16) << 2) + 32'($urandom % 4);
      doReq(a, ($urandom % 8) == 0, h);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule